// File: doc/BRIEF.md
# Half-Bridge Gate Control with Dead-Time

This block turns command bits into gate enables for a bank of half-bridge output stages. Each channel has one high-side enable and one low-side enable. Per channel, the inputs are an enable bit and a side-select bit. Two external PWM pins can also drive the first two channels. A per-channel fault disable and a global supply lockout can force any channel off. A channel is active when its enable bit is set, or when its PWM pin is high (first two channels only), and when neither its fault nor the lockout is asserted. An active channel drives exactly one side. An inactive channel drives neither side, so its output floats.

The two drivers of a channel are never on together. When a driver turns off, the channel waits before any driver is allowed back on. This break-before-make wait lasts `dead_cycles` + 1 clock cycles and applies to every changeover between the two sides. Turn-off always happens at once. Only turn-on is ever delayed. The PWM pins are asynchronous, so each passes through a two-flop synchronizer before use. All interfaces are plain level-sensitive control pins with no handshake.

Top module: `hbg_gate_ctrl`

## Requirements
- R1: A channel that is not active (enable bit 0 and, on the first two channels, its PWM pin low) has both `hs_gate` and `ls_gate` low.
- R2: For an active channel, `hb_cfg` bit 1 selects the high side only and bit 0 selects the low side only. Bit i of every per-channel vector belongs to channel i+1. From an idle channel with no pending dead time, the selected gate rises at the first clock edge after the command.
- R3: `pwm_pin[0]` and `pwm_pin[1]` are ORed with the enable bits of channels 1 and 2 only, and have no effect on the other channels. A PWM edge reaches the gate at the third clock edge after it is applied: two synchronizer flops plus the output register.
- R4: `hs_gate[i]` and `ls_gate[i]` are never high in the same cycle.
- R5: On a changeover between sides, both gates of that channel stay low for exactly `dead_cycles` + 1 clock cycles before the new side turns on.
- R6: A set `ch_fault` bit forces both gates of that channel low at the next clock edge. `supply_lock` does the same for all channels. Either one overrides the enable bits and the PWM pins.
- R7: Deactivating a channel turns its driver off at the next clock edge, with no delay.
- R8: After any gate of a channel falls, no gate of that channel rises for at least `dead_cycles` + 1 cycles. `dead_cycles` is changed only while the gates involved are idle.
- R9: Enable and side-select changes made while `supply_lock` is high take effect at the first clock edge after the lock is released, once the dead time has expired.
- R10: While `rst_n` is low, and right after reset, all gates are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dead_cycles | input | DT_W | Break-before-make count, in clocks (the gap is this value + 1) |
| hb_en | input | NCH | Per-channel enable bit |
| hb_cfg | input | NCH | Per-channel side select: 1 = high side, 0 = low side |
| pwm_pin | input | NPWM | Asynchronous PWM inputs for channels 1..NPWM |
| ch_fault | input | NCH | Per-channel latched fault disable |
| supply_lock | input | 1 | Global supply lockout |
| hs_gate | output | NCH | High-side gate enable per channel |
| ls_gate | output | NCH | Low-side gate enable per channel |

## Verification
Command, fault and lockout inputs are due on the gates one edge after they are driven. PWM pins are due three edges after they are driven. A changeover leaves both gates low for `dead_cycles` + 1 edges and then raises the new side. The bench drives inputs just after a falling edge and samples just after the edge on which each result is due, and it also samples the cycle before, to show that nothing arrives early. The combination sweep first idles every channel for longer than the dead time and then waits past the PWM latency, so its expected vectors depend on the input combination alone.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  typedef enum logic {
    SIDE_LOW  = 1'b0,
    SIDE_HIGH = 1'b1
  } side_e;

  localparam int unsigned HBG_NCH_DEF  = 6;
  localparam int unsigned HBG_NPWM_DEF = 2;
  localparam int unsigned HBG_DTW_DEF  = 4;
endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_in;
      stab_q <= meta_q;
    end
  end

  assign sync_out = stab_q;
endmodule

// File: rtl/hbg_leg.sv
module hbg_leg
  import hbg_pkg::*;
#(
  parameter int unsigned DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  side_e           want_side,
  input  logic [DT_W-1:0] dead_cycles,
  output logic            hs_on,
  output logic            ls_on
);
  logic            drive_q;
  side_e           side_q;
  logic [DT_W-1:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      side_q  <= SIDE_LOW;
      wait_q  <= '0;
    end else if (!active) begin
      if (drive_q) begin
        drive_q <= 1'b0;
        wait_q  <= dead_cycles;
      end else if (wait_q != '0) begin
        wait_q <= wait_q - 1'b1;
      end
    end else if (drive_q) begin
      if (side_q != want_side) begin
        drive_q <= 1'b0;
        wait_q  <= dead_cycles;
      end
    end else if (wait_q == '0) begin
      drive_q <= 1'b1;
      side_q  <= want_side;
    end else begin
      wait_q <= wait_q - 1'b1;
    end
  end

  assign hs_on = drive_q && (side_q == SIDE_HIGH);
  assign ls_on = drive_q && (side_q == SIDE_LOW);
endmodule

// File: rtl/hbg_gate_ctrl.sv
module hbg_gate_ctrl
  import hbg_pkg::*;
#(
  parameter int unsigned NCH  = HBG_NCH_DEF,
  parameter int unsigned NPWM = HBG_NPWM_DEF,
  parameter int unsigned DT_W = HBG_DTW_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DT_W-1:0] dead_cycles,
  input  logic [NCH-1:0]  hb_en,
  input  logic [NCH-1:0]  hb_cfg,
  input  logic [NPWM-1:0] pwm_pin,
  input  logic [NCH-1:0]  ch_fault,
  input  logic            supply_lock,
  output logic [NCH-1:0]  hs_gate,
  output logic [NCH-1:0]  ls_gate
);
  logic [NPWM-1:0] pwm_s;
  logic [NCH-1:0]  ext_drive;
  logic [NCH-1:0]  chan_act;

  hbg_sync #(.W(NPWM)) u_pwm_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pwm_pin),
    .sync_out (pwm_s)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    if (g < NPWM) begin : g_pwm
      assign ext_drive[g] = pwm_s[g];
    end else begin : g_nopwm
      assign ext_drive[g] = 1'b0;
    end

    assign chan_act[g] = (hb_en[g] || ext_drive[g]) && !ch_fault[g] && !supply_lock;

    hbg_leg #(.DT_W(DT_W)) u_leg (
      .clk         (clk),
      .rst_n       (rst_n),
      .active      (chan_act[g]),
      .want_side   (hb_cfg[g] ? SIDE_HIGH : SIDE_LOW),
      .dead_cycles (dead_cycles),
      .hs_on       (hs_gate[g]),
      .ls_on       (ls_gate[g])
    );
  end
endmodule

// File: rtl/hbg_gate_ctrl_chk.sv
module hbg_gate_ctrl_chk #(
  parameter int unsigned NCH  = 6,
  parameter int unsigned NPWM = 2,
  parameter int unsigned DT_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [DT_W-1:0] dead_cycles,
  input logic [NCH-1:0]  hb_en,
  input logic [NCH-1:0]  hb_cfg,
  input logic [NPWM-1:0] pwm_pin,
  input logic [NCH-1:0]  ch_fault,
  input logic            supply_lock,
  input logic [NCH-1:0]  hs_gate,
  input logic [NCH-1:0]  ls_gate
);
  AST_LOCK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    supply_lock |=> (hs_gate == '0 && ls_gate == '0)); // R6

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    logic          was_on_q;
    logic          fell_seen_q;
    logic [DT_W:0] gap_q;
    logic          on_now;

    assign on_now = hs_gate[g] || ls_gate[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        was_on_q    <= 1'b0;
        fell_seen_q <= 1'b0;
        gap_q       <= '0;
      end else begin
        was_on_q <= on_now;
        if (was_on_q && !on_now) begin
          gap_q       <= '0;
          fell_seen_q <= 1'b1;
        end else if (gap_q != '1) begin
          gap_q <= gap_q + 1'b1;
        end
      end
    end

    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_gate[g] && ls_gate[g])); // R4

    AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ch_fault[g] |=> (!hs_gate[g] && !ls_gate[g])); // R6

    AST_CFG_HIGH_NO_LS: assert property (@(posedge clk) disable iff (!rst_n)
      hb_cfg[g] |=> !ls_gate[g]); // R2

    AST_CFG_LOW_NO_HS: assert property (@(posedge clk) disable iff (!rst_n)
      !hb_cfg[g] |=> !hs_gate[g]); // R2

    AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!was_on_q && on_now && fell_seen_q) |-> (gap_q >= {1'b0, dead_cycles})); // R8

    if (g >= NPWM) begin : g_nopwm
      AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !hb_en[g] |=> (!hs_gate[g] && !ls_gate[g])); // R1
    end
  end
endmodule

bind hbg_gate_ctrl hbg_gate_ctrl_chk #(.NCH(NCH), .NPWM(NPWM), .DT_W(DT_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dead_cycles (dead_cycles),
  .hb_en       (hb_en),
  .hb_cfg      (hb_cfg),
  .pwm_pin     (pwm_pin),
  .ch_fault    (ch_fault),
  .supply_lock (supply_lock),
  .hs_gate     (hs_gate),
  .ls_gate     (ls_gate)
);

// File: tb/test_hbg_gate_ctrl.sv
module test_hbg_gate_ctrl;
  localparam int NCH  = 6;
  localparam int NPWM = 2;
  localparam int DT_W = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [DT_W-1:0] dead_cycles = '0;
  logic [NCH-1:0]  hb_en = '0;
  logic [NCH-1:0]  hb_cfg = '0;
  logic [NPWM-1:0] pwm_pin = '0;
  logic [NCH-1:0]  ch_fault = '0;
  logic            supply_lock = 1'b0;
  logic [NCH-1:0]  hs_gate;
  logic [NCH-1:0]  ls_gate;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hbg_gate_ctrl #(.NCH(NCH), .NPWM(NPWM), .DT_W(DT_W)) i_hbg_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .dead_cycles(dead_cycles), .hb_en(hb_en),
    .hb_cfg(hb_cfg), .pwm_pin(pwm_pin), .ch_fault(ch_fault),
    .supply_lock(supply_lock), .hs_gate(hs_gate), .ls_gate(ls_gate)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic idle_all(input int n);
    hb_en = '0; hb_cfg = '0; pwm_pin = '0; ch_fault = '0; supply_lock = 1'b0;
    step(n);
  endtask

  task automatic changeover(input int dt, input int ch);
    idle_all(20);
    dead_cycles = DT_W'(dt);
    hb_en[ch] = 1'b1; hb_cfg[ch] = 1'b1;
    step(1);
    check("R2 high side on from idle", {30'd0, hs_gate[ch], ls_gate[ch]}, 32'h2);
    hb_cfg[ch] = 1'b0;
    for (int k = 0; k <= dt; k++) begin
      step(1);
      check("R5 high-to-low gap both off", {30'd0, hs_gate[ch], ls_gate[ch]}, 32'h0);
    end
    step(1);
    check("R5 low side on after gap", {30'd0, hs_gate[ch], ls_gate[ch]}, 32'h1);
    hb_cfg[ch] = 1'b1;
    for (int k = 0; k <= dt; k++) begin
      step(1);
      check("R5 low-to-high gap both off", {30'd0, hs_gate[ch], ls_gate[ch]}, 32'h0);
    end
    step(1);
    check("R5 high side on after gap", {30'd0, hs_gate[ch], ls_gate[ch]}, 32'h2);
    hb_en[ch] = 1'b0;
    step(1);
    check("R7 deactivation turns off at once", {30'd0, hs_gate[ch], ls_gate[ch]}, 32'h0);
  endtask

  initial begin
    logic [NCH-1:0] exp_hs;
    logic [NCH-1:0] exp_ls;
    dead_cycles = DT_W'(3);
    step(3);
    check("R10 gates low in reset", {20'd0, hs_gate, ls_gate}, 32'h0);
    rst_n = 1'b1;
    step(1);
    check("R10 gates low after reset", {20'd0, hs_gate, ls_gate}, 32'h0);

    // R1 R2 R3 R6 sweep over enable, side, fault, lockout and PWM
    dead_cycles = DT_W'(2);
    for (int c = 0; c < 32; c++) begin
      logic en_b, cfg_b, flt_b, lk_b, pw_b;
      {en_b, cfg_b, flt_b, lk_b, pw_b} = c[4:0];
      idle_all(8);
      hb_en = {NCH{en_b}}; hb_cfg = {NCH{cfg_b}}; ch_fault = {NCH{flt_b}};
      supply_lock = lk_b; pwm_pin = {NPWM{pw_b}};
      step(6);
      for (int i = 0; i < NCH; i++) begin
        logic act;
        act = (en_b || (i < NPWM && pw_b)) && !flt_b && !lk_b;
        exp_hs[i] = act && cfg_b;
        exp_ls[i] = act && !cfg_b;
      end
      check("R1 R2 R3 R6 sweep", {20'd0, hs_gate, ls_gate}, {20'd0, exp_hs, exp_ls});
    end

    changeover(3, 2);
    changeover(0, 4);
    changeover(7, 5);

    // R3 PWM latency on channel 1 (high side) and channel 2 (low side)
    idle_all(20);
    dead_cycles = DT_W'(1);
    hb_cfg[0] = 1'b1; hb_cfg[1] = 1'b0;
    pwm_pin = 2'b11;
    step(2);
    check("R3 PWM not yet through", {30'd0, hs_gate[0], ls_gate[1]}, 32'h0);
    step(1);
    check("R3 PWM on at third edge", {30'd0, hs_gate[0], ls_gate[1]}, 32'h3);
    check("R3 PWM no effect on channels 3-6", {26'd0, hs_gate[5:2], ls_gate[5:2]} , 32'h0);
    pwm_pin = 2'b00;
    step(2);
    check("R3 PWM low not yet through", {30'd0, hs_gate[0], ls_gate[1]}, 32'h3);
    step(1);
    check("R3 PWM off at third edge", {30'd0, hs_gate[0], ls_gate[1]}, 32'h0);

    // R6 fault overrides PWM drive
    idle_all(10);
    hb_cfg[0] = 1'b1; pwm_pin[0] = 1'b1;
    step(4);
    check("R3 PWM drives high side", {31'd0, hs_gate[0]}, 32'h1);
    ch_fault[0] = 1'b1;
    step(1);
    check("R6 fault forces off next edge", {30'd0, hs_gate[0], ls_gate[0]}, 32'h0);

    // R9 configuration change during lockout
    idle_all(10);
    dead_cycles = DT_W'(2);
    hb_en[3] = 1'b1; hb_cfg[3] = 1'b0;
    step(1);
    check("R2 low side on", {30'd0, hs_gate[3], ls_gate[3]}, 32'h1);
    supply_lock = 1'b1;
    step(1);
    check("R6 lockout forces off", {20'd0, hs_gate, ls_gate}, 32'h0);
    hb_cfg[3] = 1'b1;
    step(10);
    check("R9 still off during lockout", {30'd0, hs_gate[3], ls_gate[3]}, 32'h0);
    supply_lock = 1'b0;
    step(1);
    check("R9 new side after release", {30'd0, hs_gate[3], ls_gate[3]}, 32'h2);

    // R8 re-enable soon after turn-off waits out the dead time
    dead_cycles = DT_W'(2);
    hb_en[3] = 1'b0;
    step(1);
    check("R7 off at once", {30'd0, hs_gate[3], ls_gate[3]}, 32'h0);
    hb_en[3] = 1'b1;
    step(2);
    check("R8 held off within dead time", {30'd0, hs_gate[3], ls_gate[3]}, 32'h0);
    step(1);
    check("R8 back on after dead time", {30'd0, hs_gate[3], ls_gate[3]}, 32'h2);

    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 20000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule